// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits beside the instruction fetch stage and is looked up with every fetch address. It is a small fully-associative store. Each entry pairs the complete address of a branch with the address that followed it the last time it was taken. When the fetch address matches a stored branch exactly, the block offers the stored address as the next fetch address. Otherwise it offers the sequential address. A branch is only ever redirected by an exact whole-address match, so one branch never borrows another branch's target.

The execute stage reports each resolved branch: its address, whether it was taken, and where it actually went. The block compares that report against its current contents. A taken branch that is not present is inserted. A present branch that went somewhere else has its target corrected. A present branch that fell through is removed. In each of these three cases the block raises a one-cycle flush with the address fetch must restart from.

Free slots are filled first, lowest slot first. Once every slot is valid, a round-robin pointer picks the victim.

Top module: `branch_target_buf`

## Requirements
- R1: After a synchronous reset every entry is invalid. `pred_hit` and `flush_req` read 0, and every lookup misses until an insertion.
- R2: The lookup result is registered. A fetch presented before clock edge k shows its result on `pred_hit` and `pred_next_pc` after edge k. With `fetch_valid` low, `pred_hit` is 0 after that edge.
- R3: A fetch address equal in all PC_W bits to a valid entry's branch address gives `pred_hit`=1, with `pred_next_pc` equal to that entry's stored target.
- R4: A fetch address that matches no valid entry gives `pred_hit`=0 and `pred_next_pc` = fetch address + INSTR_BYTES (4 by default). This includes an address that differs from a stored one only in its upper bits.
- R5: A resolved taken branch that is not in the buffer is inserted with its actual target. After the edge that samples it, `flush_req`=1 and `restart_pc` = actual target.
- R6: A resolved not-taken branch that is in the buffer is removed. `flush_req`=1 and `restart_pc` = branch address + INSTR_BYTES, and later lookups of it miss.
- R7: A resolved taken branch that is in the buffer with a different stored target gets its target overwritten. `flush_req`=1 and `restart_pc` = actual target.
- R8: A present taken branch with a matching target, and an absent not-taken branch, change nothing. `flush_req` stays 0 and nothing is inserted.
- R9: Insertion uses the lowest-numbered invalid slot. When all ENTRIES slots are valid, it replaces the slot under a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on such full-buffer replacements.
- R10: A lookup and a resolve in the same cycle for the same address return the contents from before the update. The update is visible from the next cycle.
- R11: `flush_req` and `restart_pc` are registered. They are valid for exactly the one cycle after the edge that samples the resolve, and `flush_req` is 0 in cycles with no mispredicting resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | PC_W | Fetch address to look up |
| pred_hit | output | 1 | Registered: the last fetch matched an entry |
| pred_next_pc | output | PC_W | Registered: stored target on a hit, sequential address on a miss |
| res_valid | input | 1 | A branch resolution is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | The resolved branch was taken |
| res_target | input | PC_W | Actual target of the resolved branch |
| flush_req | output | 1 | Registered: discard younger fetches and restart |
| restart_pc | output | PC_W | Registered: address to restart fetch from |

## Verification
The bench aims at four corner cases.

- Exact-match rule. It looks up an address that differs from a stored branch only in its top bit. A design that compared a truncated index would report a false hit with the wrong target.
- Same-cycle lookup and insert. It presents a lookup and an insert for the same address in the same cycle. A design that forwarded the write would hit one cycle early.
- Replacement order. It fills all sixteen slots, then inserts two more branches and checks that the first and second oldest slots are the ones that vanish. It then frees a middle slot and checks that the next insertion reuses that hole rather than evicting a live entry. A design with a wrong pointer or no free-slot preference would lose the wrong branch.
- Resolve outcomes. It covers each resolve outcome, including the silent ones. A design that flushed on a correct prediction, or inserted a not-taken branch, would show a spurious flush or a later hit.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action chosen for a resolved branch
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_INSERT = 2'd1,
    ACT_FIX    = 2'd2,
    ACT_DROP   = 2'd3
  } res_act_e;

endpackage

// File: rtl/btb_entry_store.sv
module btb_entry_store #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PC_W-1:0]  tag_arr [ENTRIES],
  output logic [PC_W-1:0]  tgt_arr [ENTRIES]
);

  // Only the valid bits are reset. Tags and targets are plain storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else begin
      if (clr_en) valid_vec[clr_idx] <= 1'b0;
      if (wr_en)  valid_vec[wr_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_arr[wr_idx] <= wr_tag;
      tgt_arr[wr_idx] <= wr_tgt;
    end
  end

endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [PC_W-1:0]    tag_arr [ENTRIES],
  input  logic [PC_W-1:0]    key,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // Full-width comparators, one per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tag_arr[g] == key);
  end

  assign hit = |match_vec;

  // Lowest matching slot wins (at most one matches in practice)
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid_vec;

  // Lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_idx = all_full ? rr_ptr : free_idx;

  // The pointer moves only when it was actually used as the victim
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (alloc && all_full) begin
      if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
      else                               rr_ptr <= rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/branch_target_buf.sv
module branch_target_buf #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            flush_req,
  output logic [PC_W-1:0] restart_pc
);
  import btb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(INSTR_BYTES);

  logic [ENTRIES-1:0] valid_vec;
  logic [PC_W-1:0]    tag_arr [ENTRIES];
  logic [PC_W-1:0]    tgt_arr [ENTRIES];

  logic [ENTRIES-1:0] f_match_vec, r_match_vec;
  logic               f_hit, r_hit;
  logic [IDX_W-1:0]   f_idx, r_idx, victim_idx;

  res_act_e           act;
  logic               res_flush;
  logic [PC_W-1:0]    res_restart;
  logic               wr_en, clr_en;
  logic [IDX_W-1:0]   wr_idx;

  btb_entry_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (res_pc),
    .wr_tgt   (res_target),
    .clr_en   (clr_en),
    .clr_idx  (r_idx),
    .valid_vec(valid_vec),
    .tag_arr  (tag_arr),
    .tgt_arr  (tgt_arr)
  );

  // Fetch-side lookup
  btb_match #(.PC_W(PC_W), .ENTRIES(ENTRIES)) fetch_match_i (
    .valid_vec(valid_vec),
    .tag_arr  (tag_arr),
    .key      (fetch_pc),
    .match_vec(f_match_vec),
    .hit      (f_hit),
    .hit_idx  (f_idx)
  );

  // Resolve-side lookup against the current contents
  btb_match #(.PC_W(PC_W), .ENTRIES(ENTRIES)) res_match_i (
    .valid_vec(valid_vec),
    .tag_arr  (tag_arr),
    .key      (res_pc),
    .match_vec(r_match_vec),
    .hit      (r_hit),
    .hit_idx  (r_idx)
  );

  btb_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .alloc     (act == ACT_INSERT),
    .victim_idx(victim_idx)
  );

  // Resolve decision
  always_comb begin
    act         = ACT_NONE;
    res_flush   = 1'b0;
    res_restart = res_target;
    if (res_valid) begin
      if (r_hit) begin
        if (!res_taken) begin
          act         = ACT_DROP;
          res_flush   = 1'b1;
          res_restart = res_pc + SEQ_STEP;
        end else if (tgt_arr[r_idx] != res_target) begin
          act       = ACT_FIX;
          res_flush = 1'b1;
        end
      end else if (res_taken) begin
        act       = ACT_INSERT;
        res_flush = 1'b1;
      end
    end
  end

  assign wr_en  = (act == ACT_INSERT) || (act == ACT_FIX);
  assign wr_idx = (act == ACT_INSERT) ? victim_idx : r_idx;
  assign clr_en = (act == ACT_DROP);

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_hit     <= 1'b0;
      pred_next_pc <= '0;
      flush_req    <= 1'b0;
      restart_pc   <= '0;
    end else begin
      pred_hit     <= fetch_valid && f_hit;
      pred_next_pc <= (fetch_valid && f_hit) ? tgt_arr[f_idx] : fetch_pc + SEQ_STEP;
      flush_req    <= res_flush;
      restart_pc   <= res_restart;
    end
  end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 16,
  parameter int INSTR_BYTES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_valid,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               pred_hit,
  input logic [PC_W-1:0]    pred_next_pc,
  input logic               res_valid,
  input logic [PC_W-1:0]    res_pc,
  input logic               res_taken,
  input logic [PC_W-1:0]    res_target,
  input logic               flush_req,
  input logic [PC_W-1:0]    restart_pc,
  input logic               r_hit,
  input logic [ENTRIES-1:0] f_match_vec
);

  // R1: first cycle out of reset is idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_hit && !flush_req));

  // R2: no fetch, no hit
  assert_no_fetch_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(fetch_valid) |-> !pred_hit);

  // R4: a miss predicts the sequential address
  assert_miss_sequential_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(fetch_valid) && !pred_hit) |-> pred_next_pc == $past(fetch_pc) + PC_W'(INSTR_BYTES));

  // R3: no branch address is held twice
  assert_unique_match_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(f_match_vec));

  // R5, R7: a taken mispredict restarts at the actual target
  assert_taken_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (flush_req && $past(res_taken)) |-> restart_pc == $past(res_target));

  // R6: a not-taken flush restarts after the branch
  assert_nt_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !$past(res_taken)) |-> restart_pc == $past(res_pc) + PC_W'(INSTR_BYTES));

  // R8: an absent not-taken branch causes no flush
  assert_quiet_nt_miss_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(res_valid) && !$past(res_taken) && !$past(r_hit)) |-> !flush_req);

  // R11: no resolve, no flush
  assert_flush_needs_resolve_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(res_valid) |-> !flush_req);

endmodule

bind branch_target_buf btb_checker #(
  .PC_W(PC_W), .ENTRIES(ENTRIES), .INSTR_BYTES(INSTR_BYTES)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .pred_hit    (pred_hit),
  .pred_next_pc(pred_next_pc),
  .res_valid   (res_valid),
  .res_pc      (res_pc),
  .res_taken   (res_taken),
  .res_target  (res_target),
  .flush_req   (flush_req),
  .restart_pc  (restart_pc),
  .r_hit       (r_hit),
  .f_match_vec (f_match_vec)
);

// File: tb/branch_target_buf_tb_top.sv
`timescale 1ns/1ps
module branch_target_buf_tb_top;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_hit;
  logic [PC_W-1:0] pred_next_pc;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic            flush_req;
  logic [PC_W-1:0] restart_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_target_buf #(.PC_W(PC_W), .ENTRIES(16), .INSTR_BYTES(4)) dut_i (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
    .flush_req(flush_req), .restart_pc(restart_pc)
  );

  typedef struct packed {
    logic            chk_fetch;
    logic            hit;
    logic [PC_W-1:0] nxt;
    logic            flush;
    logic [PC_W-1:0] rpc;
  } exp_t;

  exp_t  exp_q [$];
  string req_q [$];

  // Driver: one cycle of stimulus plus its expected result
  task automatic step(input string req,
                      input bit fv, input logic [PC_W-1:0] fpc,
                      input bit rv, input logic [PC_W-1:0] rpc, input bit rtk,
                      input logic [PC_W-1:0] rtgt,
                      input bit chk_f, input bit ehit, input logic [PC_W-1:0] enxt,
                      input bit eflush, input logic [PC_W-1:0] erpc);
    exp_t e;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc;
    res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtgt;
    e.chk_fetch = chk_f; e.hit = ehit; e.nxt = enxt; e.flush = eflush; e.rpc = erpc;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] pc, input bit ehit,
                      input logic [PC_W-1:0] enxt);
    step(req, 1, pc, 0, 0, 0, 0, 1, ehit, enxt, 0, 0);
  endtask

  task automatic resolve(input string req, input logic [PC_W-1:0] pc, input bit tk,
                         input logic [PC_W-1:0] tgt, input bit eflush,
                         input logic [PC_W-1:0] erpc);
    step(req, 0, 0, 1, pc, tk, tgt, 0, 0, 0, eflush, erpc);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (pred_hit !== e.hit || (e.chk_fetch && pred_next_pc !== e.nxt)) begin
        failures++;
        $display("FAIL %s lookup: hit=%0b next=%h expected hit=%0b next=%h",
                 r, pred_hit, pred_next_pc, e.hit, e.nxt);
      end
      if (flush_req !== e.flush || (e.flush && restart_pc !== e.rpc)) begin
        failures++;
        $display("FAIL %s resolve: flush=%0b restart=%h expected flush=%0b restart=%h",
                 r, flush_req, restart_pc, e.flush, e.rpc);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] PA = 32'h0000_0100;
  localparam logic [PC_W-1:0] PB = 32'h0000_0200;

  function automatic logic [PC_W-1:0] fp(input int i);
    return 32'h0000_1000 + PC_W'(i * 4);
  endfunction
  function automatic logic [PC_W-1:0] ft(input int i);
    return 32'h0000_4000 + PC_W'(i * 16);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, then an empty buffer misses
    step("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R1 empty miss", PA, 0, PA + 4);
    // R5 insert + R10 same-cycle lookup sees the old contents
    step("R5/R10 insert same cycle", 1, PA, 1, PA, 1, 32'h800, 1, 0, PA + 4, 1, 32'h800);
    look("R3 hit", PA, 1, 32'h800);
    look("R4 upper-bit alias miss", PA | 32'h8000_0000, 0, (PA | 32'h8000_0000) + 4);
    // R8 correct prediction is quiet
    resolve("R8 correct taken", PA, 1, 32'h800, 0, 0);
    look("R8 entry kept", PA, 1, 32'h800);
    // R7 wrong target
    resolve("R7 wrong target", PA, 1, 32'h900, 1, 32'h900);
    look("R7 target fixed", PA, 1, 32'h900);
    // R8 absent not-taken
    resolve("R8 absent not taken", PB, 0, 32'h700, 0, 0);
    look("R8 no insert", PB, 0, PB + 4);
    // R6 delete
    resolve("R6 hit not taken", PA, 0, 32'h900, 1, PA + 4);
    look("R6 removed", PA, 0, PA + 4);
    // R2 no fetch
    step("R2 fetch idle", 0, PA, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 fill all slots
    for (int i = 0; i < 16; i++) resolve("R9 fill", fp(i), 1, ft(i), 1, ft(i));
    for (int i = 0; i < 16; i++) look("R9 all held", fp(i), 1, ft(i));
    resolve("R9 evict first", fp(16), 1, ft(16), 1, ft(16));
    look("R9 slot0 evicted", fp(0), 0, fp(0) + 4);
    look("R9 new held", fp(16), 1, ft(16));
    look("R9 slot1 kept", fp(1), 1, ft(1));
    resolve("R9 evict second", fp(17), 1, ft(17), 1, ft(17));
    look("R9 slot1 evicted", fp(1), 0, fp(1) + 4);
    look("R9 slot2 kept", fp(2), 1, ft(2));
    // R9 free slot preferred over round-robin
    resolve("R6 drop slot5", fp(5), 0, 0, 1, fp(5) + 4);
    resolve("R9 fill hole", fp(18), 1, ft(18), 1, ft(18));
    look("R9 hole filled", fp(18), 1, ft(18));
    look("R9 rr victim spared", fp(2), 1, ft(2));
    look("R9 other kept", fp(6), 1, ft(6));
    step("R11 quiet", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    fetch_valid = 0; res_valid = 0;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule